// File: doc/BRIEF.md
# Local Interrupt Vector Table Register Bank

This block is the register file of a per-processor interrupt controller. Software reaches it through a single 32-bit read/write port. It holds these registers:

- an identity register;
- a fixed version word that also reports how many vector table slots are built;
- a spurious-vector register, which also carries the global software enable;
- one vector table slot per local interrupt source. The sources are the timer, two external pins, the error path, the performance counter and the thermal sensor.

Each slot stores a vector, a delivery mode, polarity, trigger mode and a mask bit.

The block also checks software for two kinds of error: writing a slot with a vector below 16 in fixed delivery mode, and touching an offset that does not exist. Each error is recorded in a collection register. Software copies the collection into the readable error word by writing that word, then reads it. When a fresh error arrives and the error slot is unmasked, the block pulses an interrupt request. Interrupt bus messaging, priority and in-service tracking are handled elsewhere.

Top module: `lvt_regbank`

## Requirements
- R1: After reset, every implemented slot reads 0x0001_0000 (mask bit 16 set, all else 0). The spurious register reads 0x0000_000F. The error word reads 0. The identity register reads RESET_ID in bits 31:24. `err_irq` is low.
- R2: Offset 1 (version) always reads {8'h00, MAX_ENTRY, 8'h00, VERSION}, and writes to it change nothing.
- R3: Offset 0 (identity) stores bits 31:24 of a write; its bits 23:0 read 0.
- R4: Offset 2 (spurious) stores vector bits 7:4, enable at bit 8 and focus-disable at bit 9. Bits 3:0 always read 0xF and bits 31:10 read 0.
- R5: Slot offsets are 4 + index, with index 0 timer, 1 pin 0, 2 pin 1, 3 error, 4 performance, 5 thermal. A slot stores vector 7:0, mode 10:8 (000 fixed, 100 NMI, 111 external), polarity 13, trigger 15 and mask 16. Status bits 12 and 14 and all other bits read 0 whatever is written.
- R6: While the enable bit (offset 2, bit 8) is 0, a slot write with bit 16 clear leaves that slot's mask bit set.
- R7: A write to an implemented slot with vector < 16 and mode 000 collects error bit 6, even if the write sets the mask. The same vector in any other mode collects nothing.
- R8: An access to offset 10 to 15, or to a slot whose index exceeds MAX_ENTRY, collects error bit 7. Such a read returns 0 and such a write stores nothing. Slots above MAX_ENTRY do not exist.
- R9: The error word (offset 3) reads the collection captured by the last write to offset 3. Any write there captures the collection and empties it. Errors collected afterwards stay hidden until the next such write. Bits 31:8 read 0.
- R10: `err_irq` is high for exactly the cycle after an access that collects a bit not already collected, and only if the error slot's mask was 0 before that access.
- R11: `rsp_rdata` takes the addressed value one cycle after a read access and holds it through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| err_irq | output | 1 | Error interrupt request pulse |

## Verification
The directed patterns cover several cases:

- write-then-read on every register class, which separates stored bits from forced and read-only bits;
- a mask-clearing write with the enable off, then with it on;
- illegal vectors sent to masked and unmasked slots, and in fixed versus non-fixed modes, which separates error collection from interrupt signalling;
- reads of the error word placed before and after the capturing write, which show the deferred-visibility rule.

A long pseudo-random run of mixed reads and writes over all sixteen offsets is then compared cycle by cycle against a behavioural reference. That run reaches the unimplemented thermal slot, repeated errors and enable toggling in orders that the directed cases do not.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
   localparam int DW        = 32;
   localparam int NUM_SLOTS = 6;
   localparam int ERR_SLOT  = 3;

   localparam int OFS_ID       = 0;
   localparam int OFS_VER      = 1;
   localparam int OFS_SPUR     = 2;
   localparam int OFS_ESR      = 3;
   localparam int OFS_LVT_BASE = 4;

   localparam int MODE_LSB = 8;
   localparam int PEND_BIT = 12;
   localparam int POL_BIT  = 13;
   localparam int RIRR_BIT = 14;
   localparam int TRIG_BIT = 15;
   localparam int MASK_BIT = 16;

   localparam int ESR_ILLVEC  = 6;
   localparam int ESR_ILLADDR = 7;

   typedef enum logic [2:0] {
      DM_FIXED  = 3'b000,
      DM_NMI    = 3'b100,
      DM_EXTINT = 3'b111
   } dmode_e;

   typedef struct packed {
      logic       mask;
      logic       trig;
      logic       pol;
      logic [2:0] mode;
      logic [7:0] vec;
   } slot_t;

   localparam slot_t SLOT_RST = '{mask: 1'b1, trig: 1'b0, pol: 1'b0, mode: 3'b000, vec: 8'h00};

   function automatic logic [DW-1:0] slot_word(input slot_t s);
      logic [DW-1:0] w;
      w = '0;
      w[7:0]                 = s.vec;
      w[MODE_LSB +: 3]       = s.mode;
      w[POL_BIT]             = s.pol;
      w[TRIG_BIT]            = s.trig;
      w[MASK_BIT]            = s.mask;
      return w;
   endfunction
endpackage

// File: rtl/lvt_addr_dec.sv
module lvt_addr_dec
   import lvt_pkg::*;
#(
   parameter int AW        = 4,
   parameter int MAX_ENTRY = 4
) (
   input  logic [AW-1:0]        addr,
   output logic                 sel_id,
   output logic                 sel_ver,
   output logic                 sel_spur,
   output logic                 sel_esr,
   output logic [NUM_SLOTS-1:0] sel_slot,
   output logic                 bad
);
   assign sel_id   = (addr == AW'(OFS_ID));
   assign sel_ver  = (addr == AW'(OFS_VER));
   assign sel_spur = (addr == AW'(OFS_SPUR));
   assign sel_esr  = (addr == AW'(OFS_ESR));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
      if (i <= MAX_ENTRY) begin : g_on
         assign sel_slot[i] = (addr == AW'(OFS_LVT_BASE + i));
      end else begin : g_off
         assign sel_slot[i] = 1'b0;
      end
   end

   assign bad = !(sel_id | sel_ver | sel_spur | sel_esr | (|sel_slot));
endmodule

// File: rtl/lvt_slot.sv
module lvt_slot
   import lvt_pkg::*;
#(
   parameter bit IMPL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          sw_en,
   output slot_t         slot,
   output logic          ill_vec
);
   if (IMPL) begin : g_impl
      slot_t q;
      logic  unused_bits;
      assign unused_bits = ^{wdata[DW-1:MASK_BIT+1], wdata[RIRR_BIT], wdata[PEND_BIT], wdata[11]};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= SLOT_RST;
         end else if (wr_en) begin
            q.vec  <= wdata[7:0];
            q.mode <= wdata[MODE_LSB +: 3];
            q.pol  <= wdata[POL_BIT];
            q.trig <= wdata[TRIG_BIT];
            q.mask <= wdata[MASK_BIT] | (!sw_en & q.mask);
         end
      end

      assign slot    = q;
      assign ill_vec = wr_en && (wdata[MODE_LSB +: 3] == DM_FIXED) && (wdata[7:4] == 4'h0);
   end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, wdata, sw_en};
      assign slot      = SLOT_RST;
      assign ill_vec   = 1'b0;
   end
endmodule

// File: rtl/lvt_err_latch.sv
module lvt_err_latch
   import lvt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ill_vec,
   input  logic       ill_addr,
   input  logic       esr_wr,
   input  logic       irq_masked,
   output logic [7:0] esr_vis,
   output logic       irq
);
   logic [7:0] coll_q;
   logic [7:0] hit;

   always_comb begin
      hit              = '0;
      hit[ESR_ILLVEC]  = ill_vec;
      hit[ESR_ILLADDR] = ill_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coll_q  <= '0;
         esr_vis <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= (|(hit & ~coll_q)) && !irq_masked;
         if (esr_wr) begin
            esr_vis <= coll_q;
            coll_q  <= '0;
         end else begin
            coll_q <= coll_q | hit;
         end
      end
   end
endmodule

// File: rtl/lvt_regbank.sv
module lvt_regbank
   import lvt_pkg::*;
#(
   parameter int       AW        = 4,
   parameter int       MAX_ENTRY = 4,
   parameter bit [7:0] VERSION   = 8'h14,
   parameter bit [7:0] RESET_ID  = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rsp_rdata,
   output logic          err_irq
);
   localparam logic [DW-1:0] VER_WORD = {8'h00, 8'(MAX_ENTRY), 8'h00, VERSION};

   if (MAX_ENTRY < 2 || MAX_ENTRY > NUM_SLOTS - 1) begin : g_bad_max
      $error("lvt_regbank: MAX_ENTRY out of range");
   end
   if (AW < 4) begin : g_bad_aw
      $error("lvt_regbank: AW too small for the register map");
   end

   logic                 sel_id, sel_ver, sel_spur, sel_esr, bad;
   logic [NUM_SLOTS-1:0] sel_slot;
   logic                 wr, rd;
   logic [7:0]           id_q;
   logic [3:0]           spur_hi_q;
   logic                 sw_en_q, focus_q;
   slot_t                slots [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] ill_vec_v;
   logic [7:0]           esr_vis;
   logic [DW-1:0]        rd_mux;

   assign wr = req_valid &&  req_write;
   assign rd = req_valid && !req_write;

   lvt_addr_dec #(.AW(AW), .MAX_ENTRY(MAX_ENTRY)) u_dec (
      .addr     (req_addr),
      .sel_id   (sel_id),
      .sel_ver  (sel_ver),
      .sel_spur (sel_spur),
      .sel_esr  (sel_esr),
      .sel_slot (sel_slot),
      .bad      (bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q      <= RESET_ID;
         spur_hi_q <= '0;
         sw_en_q   <= 1'b0;
         focus_q   <= 1'b0;
      end else if (wr) begin
         if (sel_id) id_q <= req_wdata[31:24];
         if (sel_spur) begin
            spur_hi_q <= req_wdata[7:4];
            sw_en_q   <= req_wdata[8];
            focus_q   <= req_wdata[9];
         end
      end
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      lvt_slot #(.IMPL(i <= MAX_ENTRY)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr && sel_slot[i]),
         .wdata   (req_wdata),
         .sw_en   (sw_en_q),
         .slot    (slots[i]),
         .ill_vec (ill_vec_v[i])
      );
   end

   lvt_err_latch u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .ill_vec    (|ill_vec_v),
      .ill_addr   (req_valid && bad),
      .esr_wr     (wr && sel_esr),
      .irq_masked (slots[ERR_SLOT].mask),
      .esr_vis    (esr_vis),
      .irq        (err_irq)
   );

   always_comb begin
      rd_mux = '0;
      if (sel_id)   rd_mux = {id_q, 24'h0};
      if (sel_ver)  rd_mux = VER_WORD;
      if (sel_spur) rd_mux = {22'h0, focus_q, sw_en_q, spur_hi_q, 4'hF};
      if (sel_esr)  rd_mux = {24'h0, esr_vis};
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (sel_slot[i]) rd_mux = slot_word(slots[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rsp_rdata <= '0;
      else if (rd) rsp_rdata <= rd_mux;
   end
endmodule

// File: rtl/lvt_regbank_chk.sv
module lvt_regbank_chk
   import lvt_pkg::*;
#(
   parameter int       AW        = 4,
   parameter int       MAX_ENTRY = 4,
   parameter bit [7:0] VERSION   = 8'h14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] rsp_rdata,
   input logic          err_irq
);
   logic rd_now, slot_rd, bad_rd;
   assign rd_now  = req_valid && !req_write;
   assign slot_rd = rd_now && (int'(req_addr) >= OFS_LVT_BASE) && (int'(req_addr) <= OFS_LVT_BASE + MAX_ENTRY);
   assign bad_rd  = rd_now && (int'(req_addr) > OFS_LVT_BASE + MAX_ENTRY);

   AST_VER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && req_addr == AW'(OFS_VER)) |=> rsp_rdata == {8'h00, 8'(MAX_ENTRY), 8'h00, VERSION}); // R2
   AST_ID_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && req_addr == AW'(OFS_ID)) |=> rsp_rdata[23:0] == 24'h0); // R3
   AST_SPUR_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && req_addr == AW'(OFS_SPUR)) |=> rsp_rdata[3:0] == 4'hF); // R4
   AST_SLOT_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      slot_rd |=> (rsp_rdata[PEND_BIT] == 1'b0 && rsp_rdata[RIRR_BIT] == 1'b0)); // R5
   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bad_rd |=> rsp_rdata == '0); // R8
   AST_ESR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && req_addr == AW'(OFS_ESR)) |=> rsp_rdata[31:8] == 24'h0); // R9
   AST_IRQ_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> $past(req_valid)); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_now |=> $stable(rsp_rdata)); // R11
endmodule

bind lvt_regbank lvt_regbank_chk #(.AW(AW), .MAX_ENTRY(MAX_ENTRY), .VERSION(VERSION)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .rsp_rdata (rsp_rdata),
   .err_irq   (err_irq)
);

// File: tb/sim_lvt_regbank.sv
`timescale 1ns/1ps
module sim_lvt_regbank;
   localparam int       AW   = 4;
   localparam int       MAXE = 4;
   localparam bit [7:0] VER  = 8'h14;
   localparam bit [7:0] RID  = 8'h01;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rsp_rdata;
   logic          err_irq;

   always #5 clk = ~clk;

   lvt_regbank #(.AW(AW), .MAX_ENTRY(MAXE), .VERSION(VER), .RESET_ID(RID)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .err_irq(err_irq)
   );

   int    vectors = 0;
   int    fails   = 0;
   int    cyc     = 0;
   bit    done    = 0;
   string cur_req = "R1";

   // behavioural reference
   logic [7:0]  m_id;
   logic [31:0] m_spur;
   logic [31:0] m_ent [6];
   logic [7:0]  m_coll, m_vis;
   logic [31:0] m_rdata;
   logic        m_irq;

   function automatic bit is_slot(int a);
      return a >= 4 && a <= 4 + MAXE;
   endfunction

   function automatic logic [31:0] m_read(int a);
      if (a == 0) return {m_id, 24'h0};
      if (a == 1) return {8'h00, 8'(MAXE), 8'h00, VER};
      if (a == 2) return m_spur;
      if (a == 3) return {24'h0, m_vis};
      if (is_slot(a)) return m_ent[a-4];
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_id = RID; m_spur = 32'h0000_000F; m_coll = 0; m_vis = 0;
         m_rdata = 0; m_irq = 0;
         for (int k = 0; k < 6; k++) m_ent[k] = 32'h0001_0000;
      end else begin
         int a; logic [7:0] nb; logic [31:0] nv; bit err_masked;
         a = int'(req_addr); nb = 0;
         err_masked = m_ent[3][16];
         m_irq = 0;
         if (req_valid) begin
            if (!(a <= 3 || is_slot(a))) nb[7] = 1;
            if (!req_write) m_rdata = m_read(a);
            else begin
               if (a == 0) m_id = req_wdata[31:24];
               if (a == 2) m_spur = {22'h0, req_wdata[9:4], 4'hF};
               if (is_slot(a)) begin
                  nv = req_wdata & 32'h0001_A7FF;
                  if (!m_spur[8] && m_ent[a-4][16]) nv[16] = 1;
                  m_ent[a-4] = nv;
                  if (req_wdata[7:0] < 16 && req_wdata[10:8] == 3'b000) nb[6] = 1;
               end
            end
            m_irq = ((nb & ~m_coll) != 0) && !err_masked;
            if (req_write && a == 3) begin m_vis = m_coll; m_coll = 0; end
            else m_coll = m_coll | nb;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (rsp_rdata !== m_rdata || err_irq !== m_irq) begin
            fails++;
            $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                     cur_req, rsp_rdata, err_irq, m_rdata, m_irq);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input bit w, input int a, input logic [31:0] d);
      req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      acc(1, a, d);
   endtask

   task automatic rdc(input string req, input int a, input logic [31:0] exp);
      cur_req = req;
      acc(0, a, 32'h0);
      chk(req, rsp_rdata, exp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1", {31'h0, err_irq}, 32'h0);
      rdc("R1", 0, {RID, 24'h0});
      rdc("R2", 1, 32'h0004_0014);
      rdc("R1", 2, 32'h0000_000F);
      rdc("R1", 3, 32'h0);
      for (int k = 4; k <= 8; k++) rdc("R1", k, 32'h0001_0000);
      cur_req = "R2"; wr(1, 32'hFFFF_FFFF);
      rdc("R2", 1, 32'h0004_0014);
      cur_req = "R3"; wr(0, 32'hA5FF_FFFF);
      rdc("R3", 0, 32'hA500_0000);
      cur_req = "R6"; wr(4, 32'h0000_0030);
      rdc("R6", 4, 32'h0001_0030);
      cur_req = "R4"; wr(2, 32'hFFFF_FF30);
      rdc("R4", 2, 32'h0000_033F);
      cur_req = "R5"; wr(4, 32'hFFFF_FFFF);
      rdc("R5", 4, 32'h0001_A7FF);
      wr(5, 32'h0000_A420);
      rdc("R5", 5, 32'h0000_A420);
      cur_req = "R6"; wr(7, 32'h0000_00FE);
      rdc("R6", 7, 32'h0000_00FE);
      cur_req = "R7"; wr(6, 32'h0001_0005);
      chk("R7", {31'h0, err_irq}, 32'h1);
      rdc("R9", 3, 32'h0);
      cur_req = "R9"; wr(3, 32'h0);
      rdc("R9", 3, 32'h0000_0040);
      rdc("R8", 9, 32'h0);
      chk("R8", {31'h0, err_irq}, 32'h1);
      cur_req = "R10"; wr(12, 32'hFFFF_FFFF);
      chk("R10", {31'h0, err_irq}, 32'h0);
      cur_req = "R7"; wr(4, 32'h0000_0003);
      chk("R7", {31'h0, err_irq}, 32'h1);
      cur_req = "R9"; wr(3, 32'h0);
      rdc("R9", 3, 32'h0000_00C0);
      wr(3, 32'h0);
      rdc("R9", 3, 32'h0);
      cur_req = "R7"; wr(5, 32'h0000_0405);
      chk("R7", {31'h0, err_irq}, 32'h0);
      cur_req = "R10"; wr(7, 32'h0001_00FE);
      wr(6, 32'h0000_0001);
      chk("R10", {31'h0, err_irq}, 32'h0);
      wr(3, 32'h0);
      rdc("R9", 3, 32'h0000_0040);
      cur_req = "R10"; wr(7, 32'h0000_00FE);
      wr(6, 32'h0000_0002);
      chk("R10", {31'h0, err_irq}, 32'h1);
      wr(6, 32'h0000_0003);
      chk("R10", {31'h0, err_irq}, 32'h0);
      rdc("R11", 0, 32'hA500_0000);
      cur_req = "R11";
      repeat (3) @(negedge clk);
      wr(0, 32'h0);
      chk("R11", rsp_rdata, 32'hA500_0000);
      cur_req = "R5 random";
      lf = 32'h1234_5678;
      for (int i = 0; i < 600; i++) begin
         lf = lf * 32'd1103515245 + 32'd12345;
         if (lf[27:26] == 2'b00) @(negedge clk);
         else acc(lf[25], int'(lf[31:28]), {lf[15:0], lf[23:8]});
      end
      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule